// File: doc/BRIEF.md
# DMA Channel Address Generator

This block produces the read and write address stream for a single DMA channel. Software-side logic supplies a source start address, a destination start address and a unit count, then writes a control word. That control word picks a 16-bit or 32-bit unit size. It also picks a separate stepping rule for each side: up, down, held, or a fourth code. For the destination, the fourth code means counting up with a reload at each launch. For the source, the fourth code is an illegal value that is treated as counting up and is recorded in a sticky flag.

After a start strobe, the block issues one aligned read/write address pair per clock until the unit count is used up. It then raises a one-cycle completion pulse and drops its busy flag. The current address counters keep their values between launches. A later start therefore carries on from where the last one stopped, unless a new control write reloads both counters or the destination reload mode applies. The data movement itself happens outside this block.

Top module: `dma_addr_gen`

## Requirements
- R1: After reset, busy, done, xfer_valid and bad_src_mode are 0 and both address outputs are 0.
- R2: A control write accepted while idle loads the source and destination counters from src_start and dst_start.
- R3: A start accepted while idle with unit_count N>0 gives exactly N cycles of xfer_valid back to back, starting the cycle after start. done is high for exactly the one cycle after the last pair, and busy is 0 from the cycle after done.
- R4: Destination step code is ctrl_wdata[22:21]: 0 steps up by the unit size, 1 steps down by the unit size, 2 holds the address.
- R5: With destination code 3, the destination counter steps up and is reloaded from dst_start at every accepted start. With any other code, a start without a control write carries on from the previous counter value.
- R6: Source step code is ctrl_wdata[24:23]: 0 up, 1 down, 2 hold, and 3 steps up like code 0.
- R7: bad_src_mode becomes 1 when a start is accepted with source code 3. It stays 1 until the next accepted control write, which clears it.
- R8: ctrl_wdata[26]=1 selects 32-bit units (step 4, xfer_wide=1). ctrl_wdata[26]=0 selects 16-bit units (step 2, xfer_wide=0).
- R9: Address outputs are aligned: bit 0 forced to 0 for 16-bit units, bits 1:0 forced to 0 for 32-bit units.
- R10: A start with unit_count 0 issues no pair and gives done in the cycle after start.
- R11: Start and control writes are ignored while busy, and a start is ignored in a cycle that also carries a control write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ctrl_wr | input | 1 | Control word write strobe |
| ctrl_wdata | input | 32 | Control word (step codes, unit size) |
| src_start | input | AW | Source start address |
| dst_start | input | AW | Destination start address |
| unit_count | input | CW | Units to move per launch |
| start | input | 1 | Launch strobe |
| rd_addr | output | AW | Aligned read (source) address |
| wr_addr | output | AW | Aligned write (destination) address |
| xfer_valid | output | 1 | Address pair valid this cycle |
| xfer_wide | output | 1 | 1 = 32-bit units, 0 = 16-bit units |
| done | output | 1 | One-cycle completion pulse |
| busy | output | 1 | Transfer in progress |
| bad_src_mode | output | 1 | Sticky flag for illegal source step code |

## Verification
The scoreboard runs each combination of step codes under both unit sizes. Both sides counting up tells a copy from a swapped direction. Up against down and held against down show whether each side decodes its own bit field rather than the other side's. Unaligned start addresses separate output masking from raw counting. Two launches without a control write tell the reload code apart from carry-on behaviour. A zero count, an illegal source code, and strobes injected mid-transfer cover the completion, sticky-flag and ignore rules.

// File: rtl/dma_ag_pkg.sv
// Package: shared types and control-word field positions for the DMA
// address generator. Field positions are fixed because software encodes them.
package dma_ag_pkg;
    typedef enum logic [1:0] {
        STEP_UP   = 2'd0,
        STEP_DOWN = 2'd1,
        STEP_HOLD = 2'd2,
        STEP_ALT  = 2'd3
    } step_e;

    localparam int CTRL_W       = 32;
    localparam int DST_CODE_LSB = 21;
    localparam int SRC_CODE_LSB = 23;
    localparam int WIDE_BIT     = 26;
endpackage

// File: rtl/dma_ag_ctrl.sv
// Module: dma_ag_ctrl
// Holds the decoded control word (two step codes, unit size) and the sticky
// illegal-source-code flag. Assumes ctrl_ok/start_ok are already gated by idle.
module dma_ag_ctrl
    import dma_ag_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ctrl_ok,
    input  logic [CTRL_W-1:0] ctrl_wdata,
    input  logic              start_ok,
    output step_e             dst_code,
    output step_e             src_code,
    output logic              wide,
    output logic              bad_flag
);
    logic unused_ctrl_bits;
    assign unused_ctrl_bits = ^{ctrl_wdata[CTRL_W-1:WIDE_BIT+1],
                                ctrl_wdata[WIDE_BIT-1:SRC_CODE_LSB+2],
                                ctrl_wdata[DST_CODE_LSB-1:0]};

    // Capture the control fields on an accepted control write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dst_code <= STEP_UP;
            src_code <= STEP_UP;
            wide     <= 1'b0;
        end else if (ctrl_ok) begin
            dst_code <= step_e'(ctrl_wdata[DST_CODE_LSB +: 2]);
            src_code <= step_e'(ctrl_wdata[SRC_CODE_LSB +: 2]);
            wide     <= ctrl_wdata[WIDE_BIT];
        end
    end

    // Sticky flag: set when a launch uses the illegal source code.
    always_ff @(posedge clk) begin
        if (!rst_n)
            bad_flag <= 1'b0;
        else if (ctrl_ok)
            bad_flag <= 1'b0;
        else if (start_ok && src_code == STEP_ALT)
            bad_flag <= 1'b1;
    end

    AST_BAD_CLEARED: assert property (@(posedge clk) disable iff (!rst_n)
        ctrl_ok |=> !bad_flag); // R7
    AST_BAD_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (bad_flag && !ctrl_ok) |=> bad_flag); // R7
endmodule

// File: rtl/dma_ag_ptr.sv
// Module: dma_ag_ptr
// One address counter. It loads on a control write, optionally reloads on a
// launch when its code is STEP_ALT, and steps by +/-unit or 0 per issued pair.
// Assumes load and advance never coincide (load only while idle).
module dma_ag_ptr
    import dma_ag_pkg::*;
#(
    parameter int AW            = 32,
    parameter bit RELOAD_ON_ALT = 1'b0
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic          launch,
    input  logic          advance,
    input  step_e         code,
    input  logic          wide,
    input  logic [AW-1:0] start_val,
    output logic [AW-1:0] addr_o
);
    logic [AW-1:0] cur;
    logic [AW-1:0] unit_b;
    logic [AW-1:0] delta;
    logic [AW-1:0] align_mask;

    // Unit size in bytes and the matching alignment mask.
    always_comb begin
        unit_b     = wide ? AW'(4) : AW'(2);
        align_mask = wide ? ~AW'(3) : ~AW'(1);
    end

    // Signed step for the selected code (two's complement for down).
    always_comb begin
        case (code)
            STEP_UP:   delta = unit_b;
            STEP_DOWN: delta = AW'(0) - unit_b;
            STEP_HOLD: delta = '0;
            default:   delta = unit_b;
        endcase
    end

    // Counter update: load, optional reload at launch, then stepping.
    always_ff @(posedge clk) begin
        if (!rst_n)
            cur <= '0;
        else if (load)
            cur <= start_val;
        else if (RELOAD_ON_ALT && launch && code == STEP_ALT)
            cur <= start_val;
        else if (advance)
            cur <= cur + delta;
    end

    assign addr_o = cur & align_mask;

    AST_HOLD_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        (advance && code == STEP_HOLD) |=> $stable(cur)); // R4
    AST_DOWN_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (advance && code == STEP_DOWN) |=> cur == $past(cur) - $past(unit_b)); // R6
    AST_LOAD_VALUE: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> cur == $past(start_val)); // R2
endmodule

// File: rtl/dma_ag_seq.sv
// Module: dma_ag_seq
// Unit counter and busy/done sequencing. One pair per busy cycle while units
// remain; done in the busy cycle that finds zero left, then idle.
module dma_ag_seq #(
    parameter int CW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start_ok,
    input  logic [CW-1:0] count_in,
    output logic          busy,
    output logic          valid,
    output logic          done
);
    logic [CW-1:0] remain;

    // Load the count at launch, count down per pair, drop busy after done.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy   <= 1'b0;
            remain <= '0;
        end else if (start_ok) begin
            busy   <= 1'b1;
            remain <= count_in;
        end else if (busy) begin
            if (remain == '0)
                busy <= 1'b0;
            else
                remain <= remain - 1'b1;
        end
    end

    assign valid = busy && (remain != '0);
    assign done  = busy && (remain == '0);

    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done); // R3
    AST_DONE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !busy); // R3
    AST_BUSY_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !done) |=> busy); // R11
    AST_ZERO_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        (start_ok && count_in == '0) |=> done); // R10
endmodule

// File: rtl/dma_addr_gen.sv
// Module: dma_addr_gen (top)
// DMA channel address generator: gates strobes by idle state, then ties the
// control decode, the two address counters and the sequencer together.
// Assumes start addresses are held stable while a control write or start occurs.
module dma_addr_gen
    import dma_ag_pkg::*;
#(
    parameter int AW = 32,
    parameter int CW = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ctrl_wr,
    input  logic [CTRL_W-1:0] ctrl_wdata,
    input  logic [AW-1:0]     src_start,
    input  logic [AW-1:0]     dst_start,
    input  logic [CW-1:0]     unit_count,
    input  logic              start,
    output logic [AW-1:0]     rd_addr,
    output logic [AW-1:0]     wr_addr,
    output logic              xfer_valid,
    output logic              xfer_wide,
    output logic              done,
    output logic              busy,
    output logic              bad_src_mode
);
    logic  ctrl_ok;
    logic  start_ok;
    step_e dst_code;
    step_e src_code;
    logic  wide;

    // Strobe gating: nothing is accepted mid-transfer; control write wins.
    always_comb begin
        ctrl_ok  = ctrl_wr && !busy;
        start_ok = start && !busy && !ctrl_wr;
    end

    dma_ag_ctrl u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .ctrl_ok    (ctrl_ok),
        .ctrl_wdata (ctrl_wdata),
        .start_ok   (start_ok),
        .dst_code   (dst_code),
        .src_code   (src_code),
        .wide       (wide),
        .bad_flag   (bad_src_mode)
    );

    dma_ag_ptr #(.AW(AW), .RELOAD_ON_ALT(1'b0)) u_src (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (ctrl_ok),
        .launch    (start_ok),
        .advance   (xfer_valid),
        .code      (src_code),
        .wide      (wide),
        .start_val (src_start),
        .addr_o    (rd_addr)
    );

    dma_ag_ptr #(.AW(AW), .RELOAD_ON_ALT(1'b1)) u_dst (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (ctrl_ok),
        .launch    (start_ok),
        .advance   (xfer_valid),
        .code      (dst_code),
        .wide      (wide),
        .start_val (dst_start),
        .addr_o    (wr_addr)
    );

    dma_ag_seq #(.CW(CW)) u_seq (
        .clk      (clk),
        .rst_n    (rst_n),
        .start_ok (start_ok),
        .count_in (unit_count),
        .busy     (busy),
        .valid    (xfer_valid),
        .done     (done)
    );

    assign xfer_wide = wide;

    AST_WIDE_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !done) |=> $stable(xfer_wide)); // R8
    AST_ALIGNED: assert property (@(posedge clk) disable iff (!rst_n)
        xfer_valid |-> (rd_addr[0] == 1'b0 && wr_addr[0] == 1'b0)); // R9
endmodule

// File: tb/dma_addr_gen_test.sv
module dma_addr_gen_test;
    localparam int CLK_PERIOD = 10;
    localparam int AW = 32;
    localparam int CW = 16;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          ctrl_wr = 1'b0;
    logic [31:0]   ctrl_wdata = '0;
    logic [AW-1:0] src_start = '0;
    logic [AW-1:0] dst_start = '0;
    logic [CW-1:0] unit_count = '0;
    logic          start = 1'b0;
    logic [AW-1:0] rd_addr, wr_addr;
    logic          xfer_valid, xfer_wide, done, busy, bad_src_mode;

    dma_addr_gen #(.AW(AW), .CW(CW)) uut (
        .clk(clk), .rst_n(rst_n), .ctrl_wr(ctrl_wr), .ctrl_wdata(ctrl_wdata),
        .src_start(src_start), .dst_start(dst_start), .unit_count(unit_count),
        .start(start), .rd_addr(rd_addr), .wr_addr(wr_addr),
        .xfer_valid(xfer_valid), .xfer_wide(xfer_wide), .done(done),
        .busy(busy), .bad_src_mode(bad_src_mode)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    typedef struct packed {
        logic [AW-1:0] rd;
        logic [AW-1:0] wr;
        logic          wide;
    } pair_t;

    pair_t exp_q[$];
    int    checks = 0;
    int    fails = 0;
    int    pairs_seen = 0;
    int    dones_seen = 0;
    string tag = "R1";
    bit    finished = 1'b0;

    logic [AW-1:0] m_src, m_dst;
    logic [31:0]   m_ctrl;

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Monitor: pops expected pairs as the design issues them.
    always @(negedge clk) begin
        if (rst_n && !finished) begin
            if (xfer_valid) begin
                pairs_seen++;
                if (exp_q.size() == 0) begin
                    chk({tag, " R3 unexpected pair"}, 64'd1, 64'd0);
                end else begin
                    pair_t it;
                    it = exp_q.pop_front();
                    chk({tag, " rd_addr"}, 64'(rd_addr), 64'(it.rd));
                    chk({tag, " wr_addr"}, 64'(wr_addr), 64'(it.wr));
                    chk({tag, " R8 xfer_wide"}, 64'(xfer_wide), 64'(it.wide));
                end
            end
            if (done) begin
                dones_seen++;
                chk({tag, " R3 queue drained at done"}, 64'(exp_q.size()), 64'd0);
            end
        end
    end

    function automatic logic [AW-1:0] delta_of(input logic [1:0] code, input logic wide);
        logic [AW-1:0] u;
        u = wide ? AW'(4) : AW'(2);
        case (code)
            2'd1:    return AW'(0) - u;
            2'd2:    return '0;
            default: return u;
        endcase
    endfunction

    task automatic write_ctrl(input logic [31:0] w, input logic [AW-1:0] s, input logic [AW-1:0] d);
        @(negedge clk);
        src_start  = s;
        dst_start  = d;
        ctrl_wdata = w;
        ctrl_wr    = 1'b1;
        @(negedge clk);
        ctrl_wr = 1'b0;
        m_src = s;
        m_dst = d;
        m_ctrl = w;
    endtask

    // Driver: computes the expected stream, launches, waits for completion.
    task automatic run(input int n, input string t, input logic [AW-1:0] dstart, input bit disturb);
        logic          wide;
        logic [AW-1:0] mask;
        int            p0, d0, guard;
        wide = m_ctrl[26];
        mask = wide ? ~AW'(3) : ~AW'(1);
        tag = t;
        dst_start = dstart;
        if (m_ctrl[22:21] == 2'd3) m_dst = dstart;
        for (int i = 0; i < n; i++) begin
            exp_q.push_back('{rd: m_src & mask, wr: m_dst & mask, wide: wide});
            m_src = m_src + delta_of(m_ctrl[24:23], wide);
            m_dst = m_dst + delta_of((m_ctrl[22:21] == 2'd3) ? 2'd0 : m_ctrl[22:21], wide);
        end
        p0 = pairs_seen;
        d0 = dones_seen;
        @(negedge clk);
        unit_count = CW'(n);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        if (disturb) begin
            ctrl_wdata = 32'hFFFF_FFFF;
            ctrl_wr    = 1'b1;
            start      = 1'b1;
            src_start  = 32'hDEAD_BEE0;
            dst_start  = 32'h0BAD_F000;
            unit_count = 16'd9;
            @(negedge clk);
            ctrl_wr = 1'b0;
            start   = 1'b0;
        end
        guard = 0;
        while (dones_seen == d0 && guard < 2000) begin
            @(negedge clk);
            #1;
            guard++;
        end
        chk({t, " R3 done pulses"}, 64'(dones_seen - d0), 64'd1);
        chk({t, " R3 pair count"}, 64'(pairs_seen - p0), 64'(n));
        @(negedge clk);
        #1;
        chk({t, " R3 busy low after done"}, 64'(busy), 64'd0);
        chk({t, " R3 done one cycle"}, 64'(done), 64'd0);
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        if (!finished) begin
            finished = 1'b1;
            checks++;
            fails++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        m_src = '0; m_dst = '0; m_ctrl = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state
        chk("R1 busy", 64'(busy), 64'd0);
        chk("R1 done", 64'(done), 64'd0);
        chk("R1 xfer_valid", 64'(xfer_valid), 64'd0);
        chk("R1 bad_src_mode", 64'(bad_src_mode), 64'd0);
        chk("R1 rd_addr", 64'(rd_addr), 64'd0);
        chk("R1 wr_addr", 64'(wr_addr), 64'd0);

        // R2 R4 R6 R8: both up, 16-bit
        write_ctrl(32'h0000_0000, 32'h0000_1000, 32'h0000_2000);
        run(4, "R2 R4 R6 up/up 16b", 32'h0000_2000, 1'b0);
        // R5: no control write, carry on
        run(2, "R5 carry-on", 32'h0000_7000, 1'b0);

        // R4 R6 R8 R9: dst down, src hold, 32-bit, unaligned starts
        write_ctrl((32'd1 << 21) | (32'd2 << 23) | (32'd1 << 26), 32'h0000_3003, 32'h0000_4006);
        run(3, "R4 R6 R9 down/hold 32b", 32'h0000_4006, 1'b0);

        // R4 R6 R9: dst hold, src down, 16-bit, unaligned source
        write_ctrl((32'd2 << 21) | (32'd1 << 23), 32'h0000_5001, 32'h0000_6000);
        run(3, "R4 R6 R9 hold/down 16b", 32'h0000_6000, 1'b0);

        // R5: dst reload mode, 32-bit; second launch reloads dst only
        write_ctrl((32'd3 << 21) | (32'd1 << 26), 32'h0000_8000, 32'h0000_8800);
        run(3, "R5 reload first", 32'h0000_8800, 1'b0);
        run(3, "R5 reload second", 32'h0000_9000, 1'b0);

        // R6 R7: illegal source code counts up and sets the sticky flag
        write_ctrl(32'd3 << 23, 32'h0000_A000, 32'h0000_B000);
        @(negedge clk);
        chk("R7 flag clear before launch", 64'(bad_src_mode), 64'd0);
        run(2, "R6 R7 src code 3", 32'h0000_B000, 1'b0);
        chk("R7 flag set after launch", 64'(bad_src_mode), 64'd1);
        repeat (2) @(negedge clk);
        chk("R7 flag sticky", 64'(bad_src_mode), 64'd1);
        write_ctrl(32'h0000_0000, 32'h0000_C000, 32'h0000_D000);
        @(negedge clk);
        chk("R7 flag cleared by control write", 64'(bad_src_mode), 64'd0);

        // R10: zero count
        run(0, "R10 zero count", 32'h0000_D000, 1'b0);

        // R11: strobes while busy are ignored
        run(5, "R11 disturb", 32'h0000_D000, 1'b1);
        chk("R11 flag untouched", 64'(bad_src_mode), 64'd0);
        chk("R11 width untouched", 64'(xfer_wide), 64'd0);

        // R11: start in the same cycle as a control write is dropped
        @(negedge clk);
        src_start  = 32'h0000_E000;
        dst_start  = 32'h0000_F000;
        ctrl_wdata = 32'h0000_0000;
        unit_count = 16'd3;
        ctrl_wr    = 1'b1;
        start      = 1'b1;
        @(negedge clk);
        ctrl_wr = 1'b0;
        start   = 1'b0;
        m_src = 32'h0000_E000;
        m_dst = 32'h0000_F000;
        m_ctrl = 32'h0000_0000;
        @(negedge clk);
        chk("R11 start dropped with ctrl write", 64'(busy), 64'd0);
        run(1, "R11 R2 after combined strobe", 32'h0000_F000, 1'b0);

        finished = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule